// File: doc/BRIEF.md
# SPI Flash Erase and Status Sequencer

This block runs the command-level side of a single-lane serial flash on its own, so that a host only has to raise a request and wait. It reads the three-byte identification, sets the write enable latch, and erases a sector, a 64 KiB block or the whole device. Every command is framed by its own chip-select window. The block contains the SPI pin shifter, which works in mode 0 with MSB-first bytes.

An erase is a fixed chain of steps. First the block polls the status register until the device is idle. It then sends write enable and reads the status back to confirm that the latch is set. Next it sends the erase opcode, with a 24-bit address for sector and block erase. Finally it polls the status until the busy bit drops. Each polling phase has its own budget counted in ticks of a 1 ms strobe input. A read-ID request returns the identification and the log2 of the capacity. An identification that cannot be decoded ends with an error code.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `cs_n` is 1 and `sck`, `done` and `busy` are 0.
- R2: The SPI link runs in mode 0. `sck` idles low and is low whenever `cs_n` is high. MOSI is sampled on rising edges, bytes go out MSB first, and each command lasts exactly one `cs_n` low window: 8 clocks for write enable and chip erase, 16 for a status read, 32 for read ID and for an addressed erase.
- R3: Operation code 0 sends opcode 0x9F and gathers 24 bits. `id_out` holds them in arrival order: the first (manufacturer) byte at bits 23:16, the second at 15:8 and the third at 7:0.
- R4: A read ID that returns 0xFFFFFF or 0x000000 ends with error code 1 (no response).
- R5: If bits 11:8 of the identification are not zero, the read ends with error code 3 (unsupported) and `cap_log2` is 0. Otherwise `cap_log2` is bits 7:0, so the capacity is 2 to that power bytes.
- R6: Operation codes 2, 3 and 4 (sector, block, chip erase) run this order: idle polling with status opcode 0x05, write enable 0x06, a status check, then erase opcode 0x20, 0xD8 or 0xC7, then busy polling. Sector and block erase append `addr[23:0]` MSB first and ignore the higher address bits. A successful finish reports code 0.
- R7: If bit 1 (write enable latch) of the status read after write enable is 0, the operation ends with code 2 (not found) and no erase opcode is sent.
- R8: A polling phase finishes when status bit 0 (write in progress) reads 0. It performs at most budget+1 status reads, waits for one `tick_ms` pulse between reads and does not wait after the last one. If every read shows busy, the operation ends with code 4 (timeout).
- R9: The budget is `IDLE_MS` for idle polling, and `SECT_MS`, `BLK_MS` or `CHIP_MS` for the busy polling after a sector, block or chip erase.
- R10: `busy` is high from the cycle after a request is accepted until `done`. A request is taken only while `busy` is low, and a request raised while busy has no effect.
- R11: `done` is high for exactly one cycle and carries `err`. An operation code above 4 ends at once with code 5 and produces no SPI activity.
- R12: Operation code 1 runs idle polling, write enable and the status check alone, and ends with code 0 or code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| req | input | 1 | Start request, taken while idle |
| op | input | 3 | 0 read ID, 1 write enable, 2 sector, 3 block, 4 chip erase |
| addr | input | ADDR_W | Erase address, low 24 bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 3 | Result code, valid with done |
| id_out | output | 24 | Identification from the last read ID |
| cap_log2 | output | 8 | Log2 of capacity in bytes, 0 on failure |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest situations to reach from the ports are the polling boundaries. In one case the busy bit clears on exactly the final permitted read. In the other it is still set on that read and the operation times out. Each type of erase must also be shown to take its own budget. The bench drives a behavioural flash model whose busy bit stays set for a programmed number of status reads. That count is set equal to each budget and then one above it, while small budgets are used as parameter overrides. The model can also ignore write enable, which drives the latch check into failure, and it counts every status read so the exact number of polls can be compared.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
   localparam logic [2:0] OP_RDID = 3'd0;
   localparam logic [2:0] OP_WREN = 3'd1;
   localparam logic [2:0] OP_SECT = 3'd2;
   localparam logic [2:0] OP_BLK  = 3'd3;
   localparam logic [2:0] OP_CHIP = 3'd4;

   localparam logic [2:0] E_OK      = 3'd0;
   localparam logic [2:0] E_NORESP  = 3'd1;
   localparam logic [2:0] E_NOTFND  = 3'd2;
   localparam logic [2:0] E_UNSUP   = 3'd3;
   localparam logic [2:0] E_TIMEOUT = 3'd4;
   localparam logic [2:0] E_BADOP   = 3'd5;

   localparam logic [7:0] C_WREN = 8'h06;
   localparam logic [7:0] C_STAT = 8'h05;
   localparam logic [7:0] C_RDID = 8'h9F;
   localparam logic [7:0] C_SECT = 8'h20;
   localparam logic [7:0] C_BLK  = 8'hD8;
   localparam logic [7:0] C_CHIP = 8'hC7;

   localparam int WIP_BIT = 0;
   localparam int WEL_BIT = 1;

   typedef enum logic [3:0] {
      S_IDLE, S_RDID, S_IPOLL, S_IWAIT, S_WREN,
      S_WCHK, S_ERASE, S_EPOLL, S_EWAIT
   } seq_st_e;
endpackage

// File: rtl/fseq_shifter.sv
module fseq_shifter #(
   parameter int CLK_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [7:0]  opc,
   input  logic [23:0] adr,
   input  logic [5:0]  nbits,
   output logic        busy,
   output logic        fin,
   output logic [23:0] rx,
   output logic        sck,
   output logic        cs_n,
   output logic        mosi,
   input  logic        miso
);
   typedef enum logic [1:0] {SH_IDLE, SH_LO, SH_HI, SH_GAP} sh_st_e;

   sh_st_e      st;
   logic [31:0] tx;
   logic [5:0]  left;
   logic        half_done;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("fseq_shifter: CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_nodiv
         assign half_done = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(CLK_DIV);
         logic [DW-1:0] dcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        dcnt <= '0;
            else if (st == SH_IDLE || half_done) dcnt <= '0;
            else                               dcnt <= dcnt + 1'b1;
         end
         assign half_done = (dcnt == DW'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SH_IDLE;
         tx   <= '0;
         left <= '0;
         rx   <= '0;
         sck  <= 1'b0;
         cs_n <= 1'b1;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            SH_IDLE: if (start) begin
               tx   <= {opc, adr};
               left <= nbits;
               cs_n <= 1'b0;
               st   <= SH_LO;
            end
            SH_LO: if (half_done) begin
               sck <= 1'b1;
               rx  <= {rx[22:0], miso};
               st  <= SH_HI;
            end
            SH_HI: if (half_done) begin
               sck  <= 1'b0;
               tx   <= {tx[30:0], 1'b0};
               left <= left - 1'b1;
               if (left == 6'd1) begin
                  cs_n <= 1'b1;
                  st   <= SH_GAP;
               end else begin
                  st <= SH_LO;
               end
            end
            SH_GAP: if (half_done) begin
               fin <= 1'b1;
               st  <= SH_IDLE;
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

   assign busy = (st != SH_IDLE);
   assign mosi = tx[31];

   a_r2_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);
   a_r2_start_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/fseq_pollcnt.sv
module fseq_pollcnt #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] budget,
   input  logic          dec,
   output logic          last
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= budget + 1'b1;
      else if (dec)  cnt <= cnt - 1'b1;
   end

   assign last = (cnt == CW'(1));

   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt > CW'(1)));
endmodule

// File: rtl/fseq_iddec.sv
module fseq_iddec #(
   parameter int IDW = 24
) (
   input  logic [IDW-1:0] raw,
   output logic           no_resp,
   output logic           unsup,
   output logic [7:0]     cap
);
   generate
      if (IDW != 24) begin : g_bad_idw
         $error("fseq_iddec: IDW must be 24");
      end
   endgenerate

   assign no_resp = (raw == '0) || (&raw);
   assign unsup   = (raw[11:8] != 4'h0);
   assign cap     = raw[7:0];
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fseq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CLK_DIV = 2,
   parameter int IDLE_MS = 200,
   parameter int SECT_MS = 500,
   parameter int BLK_MS  = 1000,
   parameter int CHIP_MS = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              req,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done,
   output logic [2:0]        err,
   output logic [23:0]       id_out,
   output logic [7:0]        cap_log2,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   localparam int MAX_AB = (IDLE_MS > SECT_MS) ? IDLE_MS : SECT_MS;
   localparam int MAX_CD = (BLK_MS > CHIP_MS) ? BLK_MS : CHIP_MS;
   localparam int MAX_MS = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CW     = $clog2(MAX_MS + 2);

   generate
      if (ADDR_W < 24) begin : g_bad_addr
         $error("flash_erase_seq: ADDR_W must be at least 24");
      end
      if (IDLE_MS < 1 || SECT_MS < 1 || BLK_MS < 1 || CHIP_MS < 1) begin : g_bad_budget
         $error("flash_erase_seq: every budget must be at least 1");
      end
   endgenerate

   seq_st_e       st;
   logic [2:0]    op_q;
   logic [23:0]   addr_q;
   logic          sh_start, sh_busy, sh_fin;
   logic [7:0]    fr_opc;
   logic [5:0]    fr_bits;
   logic [23:0]   sh_rx;
   logic          pc_load, pc_dec, pc_last;
   logic [CW-1:0] pc_val, erase_bud;
   logic          id_nr, id_uns;
   logic [7:0]    id_cap;
   logic [7:0]    erase_opc;
   logic [5:0]    erase_bits;
   logic          addr_unused;

   assign addr_unused = ^addr;

   fseq_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .opc(fr_opc), .adr(addr_q),
      .nbits(fr_bits), .busy(sh_busy), .fin(sh_fin), .rx(sh_rx),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

   fseq_pollcnt #(.CW(CW)) u_poll (
      .clk(clk), .rst_n(rst_n), .load(pc_load), .budget(pc_val),
      .dec(pc_dec), .last(pc_last));

   fseq_iddec #(.IDW(24)) u_iddec (
      .raw(sh_rx), .no_resp(id_nr), .unsup(id_uns), .cap(id_cap));

   always_comb begin
      case (op_q)
         OP_SECT: begin erase_bud = CW'(SECT_MS); erase_opc = C_SECT; erase_bits = 6'd32; end
         OP_BLK:  begin erase_bud = CW'(BLK_MS);  erase_opc = C_BLK;  erase_bits = 6'd32; end
         default: begin erase_bud = CW'(CHIP_MS); erase_opc = C_CHIP; erase_bits = 6'd8;  end
      endcase
      pc_load = (st == S_IDLE && req && op >= OP_WREN && op <= OP_CHIP) ||
                (st == S_ERASE && sh_fin);
      pc_val  = (st == S_IDLE) ? CW'(IDLE_MS) : erase_bud;
      pc_dec  = (st == S_IWAIT || st == S_EWAIT) && tick_ms;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         op_q     <= OP_RDID;
         addr_q   <= '0;
         sh_start <= 1'b0;
         fr_opc   <= '0;
         fr_bits  <= '0;
         done     <= 1'b0;
         err      <= E_OK;
         id_out   <= '0;
         cap_log2 <= '0;
      end else begin
         sh_start <= 1'b0;
         done     <= 1'b0;
         case (st)
            S_IDLE: if (req) begin
               op_q   <= op;
               addr_q <= addr[23:0];
               if (op == OP_RDID) begin
                  fr_opc <= C_RDID; fr_bits <= 6'd32; sh_start <= 1'b1;
                  st <= S_RDID;
               end else if (op <= OP_CHIP) begin
                  fr_opc <= C_STAT; fr_bits <= 6'd16; sh_start <= 1'b1;
                  st <= S_IPOLL;
               end else begin
                  done <= 1'b1; err <= E_BADOP;
               end
            end
            S_RDID: if (sh_fin) begin
               done   <= 1'b1;
               id_out <= sh_rx;
               st     <= S_IDLE;
               if (id_nr) begin
                  err <= E_NORESP; cap_log2 <= '0;
               end else if (id_uns) begin
                  err <= E_UNSUP; cap_log2 <= '0;
               end else begin
                  err <= E_OK; cap_log2 <= id_cap;
               end
            end
            S_IPOLL: if (sh_fin) begin
               if (!sh_rx[WIP_BIT]) begin
                  fr_opc <= C_WREN; fr_bits <= 6'd8; sh_start <= 1'b1;
                  st <= S_WREN;
               end else if (pc_last) begin
                  done <= 1'b1; err <= E_TIMEOUT; st <= S_IDLE;
               end else begin
                  st <= S_IWAIT;
               end
            end
            S_IWAIT: if (tick_ms) begin
               fr_opc <= C_STAT; fr_bits <= 6'd16; sh_start <= 1'b1;
               st <= S_IPOLL;
            end
            S_WREN: if (sh_fin) begin
               fr_opc <= C_STAT; fr_bits <= 6'd16; sh_start <= 1'b1;
               st <= S_WCHK;
            end
            S_WCHK: if (sh_fin) begin
               if (!sh_rx[WEL_BIT]) begin
                  done <= 1'b1; err <= E_NOTFND; st <= S_IDLE;
               end else if (op_q == OP_WREN) begin
                  done <= 1'b1; err <= E_OK; st <= S_IDLE;
               end else begin
                  fr_opc <= erase_opc; fr_bits <= erase_bits; sh_start <= 1'b1;
                  st <= S_ERASE;
               end
            end
            S_ERASE: if (sh_fin) begin
               fr_opc <= C_STAT; fr_bits <= 6'd16; sh_start <= 1'b1;
               st <= S_EPOLL;
            end
            S_EPOLL: if (sh_fin) begin
               if (!sh_rx[WIP_BIT]) begin
                  done <= 1'b1; err <= E_OK; st <= S_IDLE;
               end else if (pc_last) begin
                  done <= 1'b1; err <= E_TIMEOUT; st <= S_IDLE;
               end else begin
                  st <= S_EWAIT;
               end
            end
            S_EWAIT: if (tick_ms) begin
               fr_opc <= C_STAT; fr_bits <= 6'd16; sh_start <= 1'b1;
               st <= S_EPOLL;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy = (st != S_IDLE);

   a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_spi_only_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
   localparam int CLK_PER = 10;
   localparam int NV = 16;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] addr;
      logic [23:0] idv;
      logic [7:0]  pre;
      logic [7:0]  eb;
      logic        wok;
      logic [2:0]  xerr;
      logic [23:0] xid;
      logic [7:0]  xcap;
      logic [7:0]  xopc;
      logic [23:0] xaddr;
      logic [7:0]  xrd;
   } vec_t;

   // budgets used here: idle 2, sector 3, block 4, chip 5
   localparam vec_t VECS [NV] = '{
      '{3'd0, 32'h0,        24'hEF4018, 8'd0, 8'd0, 1'b1, 3'd0, 24'hEF4018, 8'h18, 8'h00, 24'h0,      8'd0},
      '{3'd0, 32'h0,        24'hFFFFFF, 8'd0, 8'd0, 1'b1, 3'd1, 24'hFFFFFF, 8'h00, 8'h00, 24'h0,      8'd0},
      '{3'd0, 32'h0,        24'h000000, 8'd0, 8'd0, 1'b1, 3'd1, 24'h000000, 8'h00, 8'h00, 24'h0,      8'd0},
      '{3'd0, 32'h0,        24'hC84118, 8'd0, 8'd0, 1'b1, 3'd3, 24'hC84118, 8'h00, 8'h00, 24'h0,      8'd0},
      '{3'd2, 32'hAB123456, 24'h0,      8'd0, 8'd2, 1'b1, 3'd0, 24'h0,      8'h00, 8'h20, 24'h123456, 8'd5},
      '{3'd3, 32'h00FF0000, 24'h0,      8'd0, 8'd1, 1'b1, 3'd0, 24'h0,      8'h00, 8'hD8, 24'hFF0000, 8'd4},
      '{3'd4, 32'h12345678, 24'h0,      8'd0, 8'd0, 1'b1, 3'd0, 24'h0,      8'h00, 8'hC7, 24'h0,      8'd3},
      '{3'd1, 32'h0,        24'h0,      8'd0, 8'd0, 1'b1, 3'd0, 24'h0,      8'h00, 8'h00, 24'h0,      8'd2},
      '{3'd2, 32'h00002000, 24'h0,      8'd0, 8'd0, 1'b0, 3'd2, 24'h0,      8'h00, 8'h00, 24'h0,      8'd2},
      '{3'd7, 32'h0,        24'h0,      8'd0, 8'd0, 1'b1, 3'd5, 24'h0,      8'h00, 8'h00, 24'h0,      8'd0},
      '{3'd2, 32'h00000123, 24'h0,      8'd0, 8'd3, 1'b1, 3'd0, 24'h0,      8'h00, 8'h20, 24'h000123, 8'd6},
      '{3'd2, 32'h00001000, 24'h0,      8'd0, 8'd4, 1'b1, 3'd4, 24'h0,      8'h00, 8'h20, 24'h001000, 8'd6},
      '{3'd3, 32'h00010000, 24'h0,      8'd0, 8'd5, 1'b1, 3'd4, 24'h0,      8'h00, 8'hD8, 24'h010000, 8'd7},
      '{3'd4, 32'h0,        24'h0,      8'd0, 8'd5, 1'b1, 3'd0, 24'h0,      8'h00, 8'hC7, 24'h0,      8'd8},
      '{3'd2, 32'h0,        24'h0,      8'd2, 8'd0, 1'b1, 3'd0, 24'h0,      8'h00, 8'h20, 24'h0,      8'd5},
      '{3'd2, 32'h0,        24'h0,      8'd3, 8'd0, 1'b1, 3'd4, 24'h0,      8'h00, 8'h00, 24'h0,      8'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_ms = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] addr = 32'h0;
   logic        busy, done;
   logic [2:0]  err;
   logic [23:0] id_out;
   logic [7:0]  cap_log2;
   logic        sck, cs_n, mosi, miso;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   flash_erase_seq #(
      .ADDR_W(32), .CLK_DIV(2), .IDLE_MS(2), .SECT_MS(3), .BLK_MS(4), .CHIP_MS(5)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .req(req), .op(op), .addr(addr),
      .busy(busy), .done(done), .err(err), .id_out(id_out), .cap_log2(cap_log2),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

   // behavioural flash model
   int          m_rise = 0;
   logic [31:0] m_sh = '0;
   logic [7:0]  m_cmd = '0;
   logic [23:0] m_adr = '0;
   logic [23:0] m_id = '0;
   logic        m_wel = 1'b0;
   logic        m_wel_ok = 1'b1;
   int          m_busy = 0;
   int          m_ebusy = 0;
   int          m_rd_st = 0;
   int          m_rd_id = 0;
   int          m_badfr = 0;
   logic [7:0]  m_eopc = '0;
   logic [23:0] m_eadr = '0;
   logic [23:0] m_resp;

   assign m_resp = (m_cmd == 8'h9F) ? m_id :
                   (m_cmd == 8'h05) ? {6'b0, m_wel, (m_busy > 0), 16'h0} : 24'h0;
   assign miso = (m_rise >= 8 && m_rise < 32) ? m_resp[31 - m_rise] : 1'b0;

   always @(negedge cs_n) begin
      m_rise = 0;
      m_sh   = '0;
   end

   always @(posedge sck) begin
      if (!cs_n) begin
         m_sh   = {m_sh[30:0], mosi};
         m_rise = m_rise + 1;
         if (m_rise == 8)  m_cmd = m_sh[7:0];
         if (m_rise == 32) m_adr = m_sh[23:0];
      end
   end

   always @(posedge cs_n) begin
      if (m_rise >= 8) begin
         case (m_cmd)
            8'h06: begin
               if (m_rise != 8) m_badfr++;
               if (m_wel_ok) m_wel = 1'b1;
            end
            8'h05: begin
               if (m_rise != 16) m_badfr++;
               m_rd_st++;
               if (m_busy > 0) m_busy--;
            end
            8'h9F: begin
               if (m_rise != 32) m_badfr++;
               m_rd_id++;
            end
            8'h20, 8'hD8: begin
               if (m_rise != 32) m_badfr++;
               if (m_wel) begin
                  m_eopc = m_cmd; m_eadr = m_adr; m_busy = m_ebusy; m_wel = 1'b0;
               end
            end
            8'hC7: begin
               if (m_rise != 8) m_badfr++;
               if (m_wel) begin
                  m_eopc = m_cmd; m_eadr = 24'h0; m_busy = m_ebusy; m_wel = 1'b0;
               end
            end
            default: m_badfr++;
         endcase
      end else begin
         m_badfr++;
      end
   end

   // millisecond strobe
   initial begin
      forever begin
         repeat (49) @(negedge clk);
         tick_ms = 1'b1;
         @(negedge clk);
         tick_ms = 1'b0;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string err_tag(input logic [2:0] o, input logic [2:0] e);
      if (o == 3'd1) return "R12";
      case (e)
         3'd1: return "R4";
         3'd2: return "R7";
         3'd3: return "R5";
         3'd4: return "R8";
         3'd5: return "R11";
         default: return "R6";
      endcase
   endfunction

   task automatic model_setup(input logic [23:0] idv, input int pre, input int eb, input logic wok);
      m_id = idv; m_busy = pre; m_ebusy = eb; m_wel_ok = wok; m_wel = 1'b0;
      m_rd_st = 0; m_rd_id = 0; m_badfr = 0; m_eopc = '0; m_eadr = '0;
   endtask

   task automatic run_op(input logic [2:0] o, input logic [31:0] a);
      @(negedge clk);
      req = 1'b1; op = o; addr = a;
      @(negedge clk);
      req = 1'b0;
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int ndone;
      repeat (3) @(negedge clk);
      chk("R1", "cs_n at reset", cs_n, 1);
      chk("R1", "sck at reset", sck, 0);
      chk("R1", "done at reset", done, 0);
      chk("R1", "busy at reset", busy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         model_setup(VECS[i].idv, int'(VECS[i].pre), int'(VECS[i].eb), VECS[i].wok);
         run_op(VECS[i].op, VECS[i].addr);
         chk(err_tag(VECS[i].op, VECS[i].xerr), $sformatf("vec %0d err", i), err, VECS[i].xerr);
         if (VECS[i].op == 3'd0) begin
            chk("R3", $sformatf("vec %0d id", i), id_out, VECS[i].xid);
            chk("R5", $sformatf("vec %0d cap", i), cap_log2, VECS[i].xcap);
            chk("R3", $sformatf("vec %0d id reads", i), m_rd_id, 1);
         end else begin
            chk("R6", $sformatf("vec %0d erase opcode", i), m_eopc, VECS[i].xopc);
            chk("R6", $sformatf("vec %0d erase addr", i), m_eadr, VECS[i].xaddr);
            chk((VECS[i].op == 3'd3 || VECS[i].op == 3'd4) ? "R9" : "R8",
                $sformatf("vec %0d status reads", i), m_rd_st, VECS[i].xrd);
         end
         chk("R2", $sformatf("vec %0d frame lengths", i), m_badfr, 0);
         @(negedge clk);
         chk("R11", $sformatf("vec %0d done width", i), done, 0);
      end

      // R10: request during an operation is ignored
      model_setup(24'hEF4018, 0, 3, 1'b1);
      @(negedge clk);
      req = 1'b1; op = 3'd2; addr = 32'h00004000;
      @(negedge clk);
      req = 1'b0;
      repeat (20) @(negedge clk);
      chk("R10", "busy during erase", busy, 1);
      req = 1'b1; op = 3'd0;
      @(negedge clk);
      req = 1'b0;
      while (!done) @(negedge clk);
      chk("R10", "first op result", err, 0);
      chk("R10", "erase address kept", m_eadr, 24'h004000);
      ndone = 0;
      repeat (400) begin
         @(negedge clk);
         if (done) ndone++;
      end
      chk("R10", "extra completions", ndone, 0);
      chk("R10", "ignored read id frames", m_rd_id, 0);
      chk("R10", "busy after finish", busy, 0);
      chk("R2", "cs_n idle", cs_n, 1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule